// File: doc/BRIEF.md
# USB host transfer status updater

This block holds the eight-bit status byte of one USB 2.0 host transfer descriptor and rewrites it after every bus transaction that the descriptor issues. A transaction engine reports each outcome with a one-cycle completion strobe and a set of flags: timeout, CRC error, bad PID, STALL, ERR handshake, babble, overrun, underrun and missed complete-split. Endpoint context travels with the report: the speed code, whether the endpoint sits on the periodic schedule, and whether its PID is OUT. Software arms the descriptor by writing the whole byte. That write also reloads a small retry counter.

The byte mixes three kinds of bits. There are sticky error flags. There is a halt bit that always clears Active when it is set. Bit 0 means one thing or another depending on endpoint speed. From the byte and the endpoint context the block derives the next token to issue: OUT, PING, start-split or complete-split. On a receive overrun it also raises a one-cycle request to force a bus timeout.

Top module: `usb_xfer_status_upd`

## Requirements
- R1: After reset the status byte is 0x00, halted is 0 and force_timeout is 0. The bit positions are: 7 Active, 6 Halted, 5 buffer error, 4 babble, 3 transaction error, 2 missed micro-frame, 1 split state, 0 ping state or ERR flag.
- R2: A software write (sw_wr) loads sw_wdata into the byte on the next clock edge and reloads the retry counter to 3. When a write and a completion strobe fall in the same cycle, the write wins.
- R3: A completion whose report shows babble, STALL, or an error that drains the retry counter to zero sets bit 6 and clears bit 7 in that same update. The halted output mirrors bit 6.
- R4: Each completion flagged with timeout, CRC error or bad PID takes one count off the retry counter. The third such completion after arming halts the descriptor.
- R5: Babble sets bit 4 and halts the descriptor.
- R6: Overrun or underrun sets bit 5, and bit 5 then stays set until software rewrites the byte. Overrun also drives force_timeout high for exactly one cycle, the cycle after the strobe.
- R7: Timeout, CRC error or bad PID sets bit 3, and bit 3 then stays set until software rewrites the byte.
- R8: A missed complete-split sets bit 2 and clears bit 1. This applies only to full- or low-speed endpoints (ep_speed 0 or 1) on the periodic schedule. For any other endpoint the missed flag has no effect.
- R9: For full- or low-speed endpoints, a completion with no error, STALL, babble, ERR handshake or missed split toggles bit 1. next_tok is then start-split (2) when bit 1 is 0 and complete-split (3) when it is 1. For high-speed endpoints (ep_speed 2), bit 1 is left unchanged.
- R10: For a high-speed OUT endpoint, next_tok is PING (1) when bit 0 is 1 and OUT (0) when it is 0. Completions do not alter bit 0. A high-speed endpoint that is not OUT gets token OUT (0).
- R11: An ERR handshake sets bit 0 only for a full- or low-speed endpoint on the periodic schedule. Otherwise it has no effect on bit 0.
- R12: While bit 7 is 0, completion strobes are ignored. The byte, the retry counter and force_timeout all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software write strobe that arms the descriptor |
| sw_wdata | input | 8 | Byte written by software |
| done | input | 1 | Transaction completion strobe |
| rep_timeout | input | 1 | No response from the device |
| rep_crc_err | input | 1 | CRC error on the response |
| rep_bad_pid | input | 1 | Bad PID on the response |
| rep_stall | input | 1 | STALL handshake received |
| rep_err_hs | input | 1 | ERR handshake received |
| rep_babble | input | 1 | Babble detected |
| rep_overrun | input | 1 | Receive data overrun |
| rep_underrun | input | 1 | Transmit data underrun |
| rep_missed_cs | input | 1 | A required complete-split was missed |
| ep_speed | input | 2 | 0 full, 1 low, 2 high |
| ep_periodic | input | 1 | Endpoint is on the periodic schedule |
| ep_pid_out | input | 1 | Endpoint PID is OUT |
| status | output | 8 | Current status byte |
| halted | output | 1 | Descriptor halted |
| next_tok | output | 2 | Next token: 0 OUT, 1 PING, 2 start-split, 3 complete-split |
| force_timeout | output | 1 | One-cycle request to force a bus timeout |

## Verification
The bench builds the block with the default parameters: a two-bit retry counter reloaded to 3. With that reload a halt is reached after three failed completions, so the path through counter exhaustion is short. The bench also re-arms after two failures to show that the reload brings the counter back to its start. Speed, periodic and direction settings are swept so that each of the mode-dependent bits 0, 1 and 2 is seen both updating and unaffected.

// File: rtl/usb_stat_pkg.sv
package usb_stat_pkg;
    typedef enum logic [1:0] {
        TOK_OUT    = 2'd0,
        TOK_PING   = 2'd1,
        TOK_SSPLIT = 2'd2,
        TOK_CSPLIT = 2'd3
    } tok_e;

    localparam logic [1:0] SPD_FULL = 2'd0;
    localparam logic [1:0] SPD_LOW  = 2'd1;
    localparam logic [1:0] SPD_HIGH = 2'd2;

    localparam int B_ACT  = 7;
    localparam int B_HALT = 6;
    localparam int B_DBUF = 5;
    localparam int B_BABL = 4;
    localparam int B_XERR = 3;
    localparam int B_MISS = 2;
    localparam int B_SPLT = 1;
    localparam int B_PING = 0;

    typedef struct packed {
        logic timeout;
        logic crc_err;
        logic bad_pid;
        logic stall;
        logic err_hs;
        logic babble;
        logic overrun;
        logic underrun;
        logic missed_cs;
    } outcome_t;

    typedef struct packed {
        logic xact_err;
        logic fatal;
        logic buf_err;
        logic miss_eff;
        logic errhs_eff;
        logic clean;
        logic split_ep;
    } class_t;

    typedef struct packed {
        logic [7:0] stat;
        logic       ftmo;
    } st_t;
endpackage

// File: rtl/usb_stat_outcome_dec.sv
module usb_stat_outcome_dec
    import usb_stat_pkg::*;
(
    input  outcome_t   rep,
    input  logic [1:0] speed,
    input  logic       periodic,
    output class_t     cls
);
    logic split_ep;

    always_comb begin
        split_ep      = (speed != SPD_HIGH);
        cls.split_ep  = split_ep;
        cls.xact_err  = rep.timeout | rep.crc_err | rep.bad_pid;
        cls.fatal     = rep.babble | rep.stall;
        cls.buf_err   = rep.overrun | rep.underrun;
        cls.miss_eff  = rep.missed_cs & split_ep & periodic;
        cls.errhs_eff = rep.err_hs & split_ep & periodic;
        cls.clean     = ~(rep.timeout | rep.crc_err | rep.bad_pid | rep.stall |
                          rep.babble | rep.err_hs | (rep.missed_cs & split_ep & periodic));
    end
endmodule

// File: rtl/usb_stat_err_cnt.sv
module usb_stat_err_cnt #(
    parameter int CNT_W  = 2,
    parameter int RELOAD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic exhaust
);
    localparam logic [CNT_W-1:0] RLD = CNT_W'(RELOAD);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        exhaust = dec && (cnt_q <= ONE);
        if (load)
            cnt_d = RLD;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == RLD);

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
endmodule

// File: rtl/usb_stat_tok_sel.sv
module usb_stat_tok_sel
    import usb_stat_pkg::*;
(
    input  logic [7:0] stat,
    input  logic [1:0] speed,
    input  logic       pid_out,
    output tok_e       tok
);
    always_comb begin
        if (speed != SPD_HIGH)
            tok = stat[B_SPLT] ? TOK_CSPLIT : TOK_SSPLIT;
        else if (pid_out && stat[B_PING])
            tok = TOK_PING;
        else
            tok = TOK_OUT;
    end
endmodule

// File: rtl/usb_xfer_status_upd.sv
module usb_xfer_status_upd
    import usb_stat_pkg::*;
#(
    parameter int ERR_CNT_W  = 2,
    parameter int ERR_RELOAD = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic [7:0] sw_wdata,
    input  logic       done,
    input  logic       rep_timeout,
    input  logic       rep_crc_err,
    input  logic       rep_bad_pid,
    input  logic       rep_stall,
    input  logic       rep_err_hs,
    input  logic       rep_babble,
    input  logic       rep_overrun,
    input  logic       rep_underrun,
    input  logic       rep_missed_cs,
    input  logic [1:0] ep_speed,
    input  logic       ep_periodic,
    input  logic       ep_pid_out,
    output logic [7:0] status,
    output logic       halted,
    output logic [1:0] next_tok,
    output logic       force_timeout
);
    outcome_t rep;
    class_t   cls;
    tok_e     tok;
    st_t      st_d, st_q;
    logic     upd;
    logic     exhaust;

    always_comb begin
        rep.timeout   = rep_timeout;
        rep.crc_err   = rep_crc_err;
        rep.bad_pid   = rep_bad_pid;
        rep.stall     = rep_stall;
        rep.err_hs    = rep_err_hs;
        rep.babble    = rep_babble;
        rep.overrun   = rep_overrun;
        rep.underrun  = rep_underrun;
        rep.missed_cs = rep_missed_cs;
    end

    assign upd = done && st_q.stat[B_ACT] && !sw_wr;

    usb_stat_outcome_dec u_dec (
        .rep      (rep),
        .speed    (ep_speed),
        .periodic (ep_periodic),
        .cls      (cls)
    );

    usb_stat_err_cnt #(
        .CNT_W  (ERR_CNT_W),
        .RELOAD (ERR_RELOAD)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sw_wr),
        .dec     (upd && cls.xact_err),
        .exhaust (exhaust)
    );

    usb_stat_tok_sel u_tok (
        .stat    (st_q.stat),
        .speed   (ep_speed),
        .pid_out (ep_pid_out),
        .tok     (tok)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ftmo = 1'b0;
        if (sw_wr) begin
            st_d.stat = sw_wdata;
        end else if (upd) begin
            if (cls.buf_err)   st_d.stat[B_DBUF] = 1'b1;
            if (rep.babble)    st_d.stat[B_BABL] = 1'b1;
            if (cls.xact_err)  st_d.stat[B_XERR] = 1'b1;
            if (cls.errhs_eff) st_d.stat[B_PING] = 1'b1;
            if (cls.miss_eff) begin
                st_d.stat[B_MISS] = 1'b1;
                st_d.stat[B_SPLT] = 1'b0;
            end else if (cls.split_ep && cls.clean) begin
                st_d.stat[B_SPLT] = ~st_q.stat[B_SPLT];
            end
            if (cls.fatal || exhaust) begin
                st_d.stat[B_HALT] = 1'b1;
                st_d.stat[B_ACT]  = 1'b0;
            end
            st_d.ftmo = rep.overrun;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status        = st_q.stat;
    assign halted        = st_q.stat[B_HALT];
    assign next_tok      = tok;
    assign force_timeout = st_q.ftmo;

    // R3
    halt_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (rep_babble || rep_stall)) |=> (halted && !status[B_ACT]));

    // R6
    dbuf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_DBUF] && !sw_wr) |=> status[B_DBUF]);

    // R7
    xerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_XERR] && !sw_wr) |=> status[B_XERR]);

    // R12
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[B_ACT] && !sw_wr) |=> ($stable(status) && !force_timeout));

    // R10
    ping_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_speed == SPD_HIGH && ep_pid_out && status[B_PING]) |-> next_tok == 2'd1);

    // R2
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> status == $past(sw_wdata));
endmodule

// File: tb/tb_usb_xfer_status_upd.sv
`timescale 1ns/1ps
module tb_usb_xfer_status_upd;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_wr = 1'b0;
    logic [7:0] sw_wdata = '0;
    logic       done = 1'b0;
    logic [8:0] fl = '0;
    logic [1:0] ep_speed = 2'd0;
    logic       ep_periodic = 1'b0;
    logic       ep_pid_out = 1'b0;
    logic [7:0] status;
    logic       halted;
    logic [1:0] next_tok;
    logic       force_timeout;

    int n_chk = 0;
    int n_fail = 0;

    // flag vector: {missed, underrun, overrun, babble, err_hs, stall, bad_pid, crc, timeout}
    localparam logic [8:0] F_NONE = 9'h000, F_TMO = 9'h001, F_CRC = 9'h002, F_PID = 9'h004,
                           F_STALL = 9'h008, F_ERRHS = 9'h010, F_BABL = 9'h020,
                           F_OVR = 9'h040, F_UND = 9'h080, F_MISS = 9'h100;

    always #2 clk = ~clk;

    usb_xfer_status_upd dut (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .done(done),
        .rep_timeout(fl[0]), .rep_crc_err(fl[1]), .rep_bad_pid(fl[2]), .rep_stall(fl[3]),
        .rep_err_hs(fl[4]), .rep_babble(fl[5]), .rep_overrun(fl[6]), .rep_underrun(fl[7]),
        .rep_missed_cs(fl[8]), .ep_speed(ep_speed), .ep_periodic(ep_periodic),
        .ep_pid_out(ep_pid_out), .status(status), .halted(halted), .next_tok(next_tok),
        .force_timeout(force_timeout)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic ctx(input logic [1:0] spd, input logic per, input logic out);
        ep_speed = spd; ep_periodic = per; ep_pid_out = out;
    endtask

    task automatic arm(input logic [7:0] b);
        @(negedge clk); sw_wr = 1'b1; sw_wdata = b;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic txn(input logic [8:0] f);
        @(negedge clk); done = 1'b1; fl = f;
        @(negedge clk); done = 1'b0; fl = '0;
    endtask

    task automatic t_reset;
        chk("R1 status", status, 8'h00);
        chk("R1 halted", halted, 0);
        chk("R1 force_timeout", force_timeout, 0);
    endtask

    task automatic t_split_toggle;
        ctx(2'd0, 1'b0, 1'b0);
        arm(8'h80);
        chk("R2 armed", status, 8'h80);
        chk("R9 ssplit tok", next_tok, 2);
        txn(F_NONE);
        chk("R9 toggle to 1", status, 8'h82);
        chk("R9 csplit tok", next_tok, 3);
        txn(F_NONE);
        chk("R9 toggle to 0", status, 8'h80);
        ctx(2'd2, 1'b0, 1'b0);
        arm(8'h82);
        txn(F_NONE);
        chk("R9 hs bit1 unchanged", status, 8'h82);
    endtask

    task automatic t_xact_halt;
        ctx(2'd1, 1'b0, 1'b0);
        arm(8'h80);
        txn(F_TMO);
        chk("R7 xerr set", status, 8'h88);
        txn(F_NONE);
        chk("R7 xerr sticky", status, 8'h8A);
        txn(F_CRC);
        chk("R4 second err no halt", status, 8'h8A);
        txn(F_PID);
        chk("R4 third err halts", status, 8'h4A);
        chk("R3 halted out", halted, 1);
        txn(F_BABL | F_OVR);
        chk("R12 ignored when inactive", status, 8'h4A);
        chk("R12 no force_timeout", force_timeout, 0);
        // reload check
        arm(8'h80);
        txn(F_TMO);
        txn(F_TMO);
        arm(8'h80);
        txn(F_TMO);
        txn(F_CRC);
        chk("R2 reload keeps running", status, 8'h88);
        txn(F_PID);
        chk("R4 halt after reload", status, 8'h48);
    endtask

    task automatic t_babble_stall;
        ctx(2'd2, 1'b0, 1'b0);
        arm(8'h80);
        txn(F_BABL);
        chk("R5 babble halt", status, 8'h50);
        arm(8'h80);
        txn(F_STALL);
        chk("R3 stall halt", status, 8'h40);
    endtask

    task automatic t_buffer;
        ctx(2'd2, 1'b0, 1'b0);
        arm(8'h80);
        @(negedge clk); done = 1'b1; fl = F_OVR;
        @(negedge clk); done = 1'b0; fl = '0;
        chk("R6 overrun sets bit5", status, 8'hA0);
        chk("R6 force_timeout pulse", force_timeout, 1);
        @(negedge clk);
        chk("R6 force_timeout one cycle", force_timeout, 0);
        txn(F_NONE);
        chk("R6 bit5 sticky", status, 8'hA0);
        arm(8'h80);
        txn(F_UND);
        chk("R6 underrun sets bit5", status, 8'hA0);
        chk("R6 underrun no force", force_timeout, 0);
        @(negedge clk); sw_wr = 1'b1; sw_wdata = 8'h80; done = 1'b1; fl = F_STALL;
        @(negedge clk); sw_wr = 1'b0; done = 1'b0; fl = '0;
        chk("R2 write wins", status, 8'h80);
    endtask

    task automatic t_missed;
        ctx(2'd0, 1'b1, 1'b0);
        arm(8'h82);
        txn(F_MISS);
        chk("R8 fs periodic missed", status, 8'h84);
        ctx(2'd0, 1'b0, 1'b0);
        arm(8'h82);
        txn(F_MISS);
        chk("R8 async missed ignored", status, 8'h80);
        ctx(2'd2, 1'b1, 1'b0);
        arm(8'h80);
        txn(F_MISS);
        chk("R8 hs missed ignored", status, 8'h80);
    endtask

    task automatic t_errhs_ping;
        ctx(2'd1, 1'b1, 1'b0);
        arm(8'h80);
        txn(F_ERRHS);
        chk("R11 periodic split err", status, 8'h81);
        ctx(2'd2, 1'b1, 1'b0);
        arm(8'h80);
        txn(F_ERRHS);
        chk("R11 hs err ignored", status, 8'h80);
        ctx(2'd0, 1'b0, 1'b0);
        arm(8'h80);
        txn(F_ERRHS);
        chk("R11 async err ignored", status, 8'h80);
        ctx(2'd2, 1'b0, 1'b1);
        arm(8'h81);
        chk("R10 ping token", next_tok, 1);
        txn(F_NONE);
        chk("R10 bit0 kept", status, 8'h81);
        arm(8'h80);
        chk("R10 out token", next_tok, 0);
        ctx(2'd2, 1'b0, 1'b0);
        arm(8'h81);
        chk("R10 hs in out token", next_tok, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split_toggle();
        t_xact_halt();
        t_babble_stall();
        t_buffer();
        t_missed();
        t_errhs_ping();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #40000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule